// File: doc/BRIEF.md
# Codec Event Interrupt and Soft-Reset Controller

This block is the control and status shell for an image compression engine. The engine's datapath is outside the block. It is seen only through a start pulse, a picture-done pulse, a one-cycle strobe for each output byte, and three decode-error pulses. In return the block drives a memory-request enable. While an operation runs, the block counts output bytes and clock ticks. It stops the engine when a watchdog limit is reached or when the output grows past a programmed byte bound. It merges every event into a single interrupt line.

Software reaches the block through a simple register bus. A read returns its data one cycle after the request, with a valid flag. Software sets a byte bound, a watchdog limit and the interrupt enables. It reads status. It clears the watchdog and overflow flags by writing 1 to them. A watchdog expiry or a size overflow freezes the engine, and the engine then refuses new starts until a soft reset. Writing 1 to the soft-reset register starts a sequence that clears itself after a fixed number of cycles. The sequence wipes the flags, counters and freeze, and keeps the bound, limit and enable settings.

Register offsets, as byte addresses on the bus: status 0x00, operation 0x04, watchdog flag 0x08, overflow flag 0x0C, enables 0x10, byte bound 0x14, watchdog limit 0x18, soft reset 0x1C, byte count 0x20, tick count 0x24.

Top module: `codec_evt_ctrl`

## Requirements
- R1: When an operation ends with a done pulse and no decode error was seen, the status register (0x00) reads 0x40 (bit 6 = done) and irq goes high; the completion source needs no enable.
- R2: The completion interrupt stays asserted until software has read both the status register (0x00) and the operation register (0x04), in either order; after the second read, irq is low one cycle later and status reads 0.
- R3: With the watchdog enable (bit 0 of 0x10) set before start and the limit L in 0x18, an operation with no done pulse sets the watchdog flag (0x08 bit 0) after L running cycles, and irq goes high one cycle later; writing 1 to 0x08 bit 0 clears the flag and irq.
- R4: With the overflow enable (bit 1 of 0x10) set before start and the bound B in 0x14, the byte strobe that brings the count to B+1 sets the overflow flag (0x0C bit 0) and drops mem_req_en in the following cycle; irq follows; writing 1 to 0x0C bit 0 clears the flag.
- R5: After a watchdog expiry or an overflow, the operation register reads 2 (bit 1 = frozen, bit 0 = running) and start pulses are ignored until a soft reset, even after the flag has been cleared.
- R6: The watchdog and overflow enables are sampled at start; setting them while an operation runs has no effect on that operation.
- R7: Decode-error pulses during an operation set status bits 0 (restart marker), 1 (data count) and 2 (final block count); each drives irq only when its enable is set (0x10 bits 2, 3, 4 respectively), and after done the status reads 0x40 OR the error bits.
- R8: Writing 1 to bit 0 of 0x1C starts a soft reset: 0x1C reads 1 for 8 cycles and then 0 by itself; flags, counts and the freeze are cleared, while 0x10, 0x14 and 0x18 keep their values.
- R9: Without the overflow enable, bytes beyond the bound neither halt the engine nor raise irq.
- R10: mem_req_en is high from the cycle after an accepted start until the cycle after the operation ends, and is low after reset.
- R11: The byte count register (0x20) reads the number of byte strobes received since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| start | input | 1 | Start pulse from the engine sequencer |
| done_in | input | 1 | Picture finished pulse |
| byte_stb | input | 1 | One output byte produced |
| err_in | input | 3 | Decode errors: restart marker, data count, final block count |
| mem_req_en | output | 1 | Memory requests allowed |
| irq | output | 1 | Interrupt request |

## Verification
The completion path is tried twice: once clean, and once with decode errors of which only one has its enable set. Together these show whether the status code, the per-error enables and the two-read release work, with the registers read in both orders. The watchdog is run against a limit and checked one cycle before and one cycle after the expected expiry. A bound is crossed by exactly one byte with the overflow enable armed, and crossed again with it clear, which shows whether the halt depends on the enable. A run with an enable set only after start shows whether enables are sampled at start. Soft resets in between show which registers survive and whether frozen starts are refused.

// File: rtl/codec_evt_pkg.sv
package codec_evt_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] A_STAT  = 6'h00;
  localparam logic [REG_AW-1:0] A_OPER  = 6'h04;
  localparam logic [REG_AW-1:0] A_TFLG  = 6'h08;
  localparam logic [REG_AW-1:0] A_OFLG  = 6'h0C;
  localparam logic [REG_AW-1:0] A_IEN   = 6'h10;
  localparam logic [REG_AW-1:0] A_BOUND = 6'h14;
  localparam logic [REG_AW-1:0] A_TLIM  = 6'h18;
  localparam logic [REG_AW-1:0] A_SRST  = 6'h1C;
  localparam logic [REG_AW-1:0] A_BCNT  = 6'h20;
  localparam logic [REG_AW-1:0] A_TCNT  = 6'h24;

  localparam int ERR_N  = 3;
  localparam int IEN_W  = 2 + ERR_N;
  localparam int IEN_TMR = 0;
  localparam int IEN_OVF = 1;
  localparam int IEN_ERR = 2;
endpackage

// File: rtl/codec_evt_cnt.sv
module codec_evt_cnt #(
  parameter int W      = 32,
  parameter bit STRICT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W:0] nxt;
  assign nxt = {1'b0, cnt} + 1'b1;

  generate
    if (STRICT) begin : g_gt
      assign hit = inc && (nxt > {1'b0, limit});
    end else begin : g_ge
      assign hit = inc && (nxt >= {1'b0, limit});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !(&cnt)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/codec_evt_srst.sv
module codec_evt_srst #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] left;
  logic [CW:0]   run;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      active <= 1'b0;
    end else if (req && !active) begin
      left   <= CW'(CYC - 1);
      active <= 1'b1;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else left <= left - 1'b1;
    end
  end

  // run length watch for the assertion below
  always_ff @(posedge clk) begin
    if (rst || !active) run <= '0;
    else run <= run + 1'b1;
  end

  AST_SRST_ENDS: assert property (@(posedge clk) disable iff (rst)
    active && left == '0 |=> !active); // R8
  AST_SRST_LEN: assert property (@(posedge clk) disable iff (rst)
    active |-> run < (CW+1)'(CYC)); // R8
endmodule

// File: rtl/codec_evt_regs.sv
module codec_evt_regs
  import codec_evt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic              done_evt,
  input  logic              tmr_evt,
  input  logic              ovf_evt,
  input  logic [ERR_N-1:0]  err_evt,
  input  logic              start_ok,
  input  logic              srst_act,
  input  logic              busy,
  input  logic              frozen,
  input  logic [DW-1:0]     byte_cnt,
  input  logic [DW-1:0]     tick_cnt,
  output logic [1:0]        arm_en,
  output logic [DW-1:0]     bound,
  output logic [DW-1:0]     tlimit,
  output logic              srst_req,
  output logic              irq
);
  logic [IEN_W-1:0] ien;
  logic             done_f, tmr_f, ovf_f;
  logic [ERR_N-1:0] errs;
  logic             seen_stat, seen_oper;
  logic             rd, wr;
  logic             rd_stat, rd_oper, both_seen;

  assign rd = bus_sel && !bus_wr;
  assign wr = bus_sel && bus_wr;
  assign rd_stat = rd && bus_addr == A_STAT;
  assign rd_oper = rd && bus_addr == A_OPER;
  assign both_seen = (seen_stat || rd_stat) && (seen_oper || rd_oper);
  assign srst_req = wr && bus_addr == A_SRST && bus_wdata[0];
  assign arm_en = ien[IEN_OVF:IEN_TMR];

  // configuration: survives soft reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ien    <= '0;
      bound  <= '1;
      tlimit <= '1;
    end else if (wr) begin
      case (bus_addr)
        A_IEN:   ien    <= bus_wdata[IEN_W-1:0];
        A_BOUND: bound  <= bus_wdata;
        A_TLIM:  tlimit <= bus_wdata;
        default: ;
      endcase
    end
  end

  // completion status and read handshake
  always_ff @(posedge clk) begin
    if (rst || srst_act || start_ok) begin
      done_f    <= 1'b0;
      errs      <= '0;
      seen_stat <= 1'b0;
      seen_oper <= 1'b0;
    end else if (done_evt) begin
      done_f    <= 1'b1;
      errs      <= errs | err_evt;
      seen_stat <= 1'b0;
      seen_oper <= 1'b0;
    end else if (done_f) begin
      if (both_seen) begin
        done_f    <= 1'b0;
        errs      <= '0;
        seen_stat <= 1'b0;
        seen_oper <= 1'b0;
      end else begin
        seen_stat <= seen_stat || rd_stat;
        seen_oper <= seen_oper || rd_oper;
      end
    end else begin
      errs <= errs | err_evt;
    end
  end

  // sticky stop flags, write one to clear
  always_ff @(posedge clk) begin
    if (rst || srst_act) begin
      tmr_f <= 1'b0;
      ovf_f <= 1'b0;
    end else begin
      if (tmr_evt) tmr_f <= 1'b1;
      else if (wr && bus_addr == A_TFLG && bus_wdata[0]) tmr_f <= 1'b0;
      if (ovf_evt) ovf_f <= 1'b1;
      else if (wr && bus_addr == A_OFLG && bus_wdata[0]) ovf_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= done_f || (tmr_f && ien[IEN_TMR]) || (ovf_f && ien[IEN_OVF])
             || (|(errs & ien[IEN_W-1:IEN_ERR]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (bus_addr)
          A_STAT:  bus_rdata <= DW'({done_f, 3'b000, errs});
          A_OPER:  bus_rdata <= DW'({frozen, busy});
          A_TFLG:  bus_rdata <= DW'(tmr_f);
          A_OFLG:  bus_rdata <= DW'(ovf_f);
          A_IEN:   bus_rdata <= DW'(ien);
          A_BOUND: bus_rdata <= bound;
          A_TLIM:  bus_rdata <= tlimit;
          A_SRST:  bus_rdata <= DW'(srst_act);
          A_BCNT:  bus_rdata <= byte_cnt;
          A_TCNT:  bus_rdata <= tick_cnt;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_SRST_WIPES: assert property (@(posedge clk) disable iff (rst)
    srst_act |=> !tmr_f && !ovf_f && !done_f); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(done_f || tmr_f || ovf_f || (|errs)) |=> !irq); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_f && !rd_stat && !rd_oper && !srst_act && !start_ok |=> done_f); // R2
endmodule

// File: rtl/codec_evt_ctrl.sv
module codec_evt_ctrl
  import codec_evt_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic              start,
  input  logic              done_in,
  input  logic              byte_stb,
  input  logic [ERR_N-1:0]  err_in,
  output logic              mem_req_en,
  output logic              irq
);
  logic             busy, frozen, srst_act, srst_req;
  logic             arm_tmr, arm_ovf, start_ok;
  logic [1:0]       arm_en;
  logic [DW-1:0]    bound, tlimit, byte_cnt, tick_cnt;
  logic             b_hit, t_hit;
  logic             done_evt, tmr_evt, ovf_evt;
  logic [ERR_N-1:0] err_evt;

  assign start_ok = start && !busy && !frozen && !srst_act;
  assign ovf_evt  = b_hit && arm_ovf;
  assign tmr_evt  = t_hit;
  assign done_evt = busy && done_in && !ovf_evt;
  assign err_evt  = busy ? err_in : '0;

  always_ff @(posedge clk) begin
    if (rst || srst_act) begin
      busy    <= 1'b0;
      frozen  <= 1'b0;
      arm_tmr <= 1'b0;
      arm_ovf <= 1'b0;
    end else if (start_ok) begin
      busy    <= 1'b1;
      arm_tmr <= arm_en[IEN_TMR];
      arm_ovf <= arm_en[IEN_OVF];
    end else begin
      if (done_evt || ovf_evt || tmr_evt) busy <= 1'b0;
      if (ovf_evt || tmr_evt) frozen <= 1'b1;
    end
  end

  assign mem_req_en = busy;

  codec_evt_cnt #(.W(DW), .STRICT(1'b1)) u_bytes (
    .clk(clk), .rst(rst), .clr(start_ok || srst_act),
    .inc(busy && byte_stb), .limit(bound), .cnt(byte_cnt), .hit(b_hit)
  );

  codec_evt_cnt #(.W(DW), .STRICT(1'b0)) u_ticks (
    .clk(clk), .rst(rst), .clr(start_ok || srst_act),
    .inc(busy && arm_tmr && !done_in), .limit(tlimit), .cnt(tick_cnt), .hit(t_hit)
  );

  codec_evt_srst #(.CYC(SRST_CYCLES)) u_srst (
    .clk(clk), .rst(rst), .req(srst_req), .active(srst_act)
  );

  codec_evt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .done_evt(done_evt), .tmr_evt(tmr_evt), .ovf_evt(ovf_evt), .err_evt(err_evt),
    .start_ok(start_ok), .srst_act(srst_act), .busy(busy), .frozen(frozen),
    .byte_cnt(byte_cnt), .tick_cnt(tick_cnt),
    .arm_en(arm_en), .bound(bound), .tlimit(tlimit), .srst_req(srst_req), .irq(irq)
  );

  AST_OVF_HALTS: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> !mem_req_en); // R4
  AST_FROZEN_NO_START: assert property (@(posedge clk) disable iff (rst)
    frozen && !busy |=> !busy); // R5
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> !mem_req_en); // R10
  AST_TMR_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    tmr_evt |-> $past(busy)); // R3
endmodule

// File: tb/test_codec_evt_ctrl.sv
`timescale 1ns/1ps
module test_codec_evt_ctrl;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          start = 1'b0, done_in = 1'b0, byte_stb = 1'b0;
  logic [2:0]    err_in = '0;
  logic          mem_req_en, irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  codec_evt_ctrl i_codec_evt_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .start(start), .done_in(done_in), .byte_stb(byte_stb), .err_in(err_in),
    .mem_req_en(mem_req_en), .irq(irq)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read data: got 0x%0h expected none", bus_rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bus_rdata, e, t);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic p_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic p_done();
    @(negedge clk); done_in = 1'b1; @(negedge clk); done_in = 1'b0;
  endtask
  task automatic p_byte();
    @(negedge clk); byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
  endtask
  task automatic p_err(input logic [2:0] v);
    @(negedge clk); err_in = v; @(negedge clk); err_in = '0;
  endtask

  task automatic soft_reset();
    wr(6'h1C, 1);
    rd(6'h1C, 1, "R8 soft reset busy");
    wait_n(8);
    rd(6'h1C, 0, "R8 soft reset self-clears");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    // reset state
    chk(irq, 0, "R10 irq after reset");
    chk(mem_req_en, 0, "R10 mem_req_en after reset");
    rd(6'h00, 0, "R1 status after reset");
    rd(6'h04, 0, "R5 oper after reset");
    rd(6'h10, 0, "R8 enables after reset");

    // clean completion, status read first
    p_start();
    chk(mem_req_en, 1, "R10 mem_req_en after start");
    repeat (3) p_byte();
    rd(6'h20, 3, "R11 byte count");
    p_done();
    wait_n(1);
    chk(irq, 1, "R1 irq on completion");
    chk(mem_req_en, 0, "R10 mem_req_en after done");
    rd(6'h00, 32'h40, "R1 clean status code");
    chk(irq, 1, "R2 irq held after status only");
    rd(6'h04, 0, "R2 oper read");
    wait_n(1);
    chk(irq, 0, "R2 irq released after both reads");
    rd(6'h00, 0, "R2 status cleared");

    // decode errors, only data-count enabled, operation read first
    wr(6'h10, 32'h08);
    p_start();
    p_err(3'b001);
    wait_n(1);
    chk(irq, 0, "R7 masked restart error");
    p_err(3'b010);
    wait_n(1);
    chk(irq, 1, "R7 enabled data-count error");
    p_done();
    rd(6'h04, 0, "R2 oper read first");
    chk(irq, 1, "R2 irq held after oper only");
    rd(6'h00, 32'h43, "R7 status with errors");
    wait_n(1);
    chk(irq, 0, "R2 irq released, reverse order");

    // watchdog
    wr(6'h18, 20);
    wr(6'h10, 32'h01);
    p_start();
    wait_n(19);
    chk(irq, 0, "R3 no expiry before limit");
    chk(mem_req_en, 1, "R3 still running before limit");
    wait_n(2);
    chk(irq, 1, "R3 irq on expiry");
    chk(mem_req_en, 0, "R3 engine stopped");
    rd(6'h08, 1, "R3 watchdog flag set");
    rd(6'h04, 2, "R5 frozen state");
    p_start();
    chk(mem_req_en, 0, "R5 start refused while frozen");
    wr(6'h08, 1);
    wait_n(1);
    chk(irq, 0, "R3 irq cleared by write-one");
    rd(6'h08, 0, "R3 flag cleared");
    p_start();
    chk(mem_req_en, 0, "R5 start refused after flag clear");

    soft_reset();
    rd(6'h04, 0, "R8 freeze cleared");
    rd(6'h10, 32'h01, "R8 enables kept");
    rd(6'h18, 20, "R8 limit kept");
    p_start();
    chk(mem_req_en, 1, "R5 start accepted after soft reset");
    p_done();
    rd(6'h00, 32'h40, "R1 clean status after soft reset");
    rd(6'h04, 0, "R2 oper read");

    // size bound
    wr(6'h10, 32'h02);
    wr(6'h14, 5);
    p_start();
    repeat (5) p_byte();
    chk(mem_req_en, 1, "R4 at bound still running");
    chk(irq, 0, "R4 no irq at bound");
    p_byte();
    chk(mem_req_en, 0, "R4 halt on byte past bound");
    wait_n(1);
    chk(irq, 1, "R4 irq on overflow");
    rd(6'h0C, 1, "R4 overflow flag");
    rd(6'h20, 6, "R11 byte count at overflow");
    wr(6'h0C, 1);
    wait_n(1);
    chk(irq, 0, "R4 irq cleared by write-one");
    rd(6'h0C, 0, "R4 flag cleared");
    soft_reset();
    rd(6'h14, 5, "R8 bound kept");
    rd(6'h20, 0, "R8 byte count cleared");

    // bound with overflow disabled
    wr(6'h10, 0);
    wr(6'h14, 2);
    p_start();
    repeat (4) p_byte();
    chk(mem_req_en, 1, "R9 no halt without enable");
    chk(irq, 0, "R9 no irq without enable");
    rd(6'h0C, 0, "R9 overflow flag stays clear");
    rd(6'h20, 4, "R11 counts past bound");
    p_done();
    rd(6'h00, 32'h40, "R1 status");
    rd(6'h04, 0, "R2 oper read");

    // enable set after start is not sampled
    wr(6'h18, 10);
    p_start();
    wr(6'h10, 32'h01);
    wait_n(30);
    chk(irq, 0, "R6 late enable ignored");
    chk(mem_req_en, 1, "R6 still running");
    rd(6'h08, 0, "R6 no watchdog flag");
    p_done();
    rd(6'h00, 32'h40, "R1 status");
    rd(6'h04, 0, "R2 oper read");

    wait_n(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL reads outstanding: got %0d expected 0", exp_q.size());
    end
    summary();
  end
endmodule